// File: doc/BRIEF.md
# Extension opcode hook unit

This block sits between the decode and writeback stages of a small five-stage in-order pipeline. It gives an optional add-on execution layer a way to run new instructions without changing the base datapath. Eight opcodes are set aside for this purpose. When no add-on claims one of them, the base core treats it as an explicit no-op. The unit copies the decoded opcode and the source register numbers onto observation outputs. For an opcode that the add-on implements, it captures both register operands for the add-on, holds the pipeline while the add-on computes, and then drives the add-on's result through an extra input on the writeback multiplexer in place of the ALU result.

The add-on here is a built-in multi-cycle stand-in, which lets the hook logic be exercised on its own. It takes a fixed number of cycles and returns the first operand rotated left by the low bits of the second operand, XORed with the second operand. The environment must hold the instruction at decode for as long as `stall` is high.

Top module: `ext_hook_unit`

## Requirements
- R1: An opcode is reserved when its three top bits are all ones (values 0x38 to 0x3F). While `ext_present` is 0, a reserved opcode writes no register (`wb_en` stays 0 in the following cycle), raises no `mem_en` and raises no `stall`.
- R2: An opcode that is not reserved completes as on the base core, whatever the values of `ext_present` and `ext_cover`. `mem_en` equals `base_mem_en` in the same cycle. In the next cycle `wb_en` equals `base_wb_en`, and `wb_rd` and `wb_data` carry `dec_rd` and `alu_result`.
- R3: `tap_opcode`, `tap_rs1` and `tap_rs2` mirror the decoded opcode and source register numbers in every cycle, and `tap_valid` mirrors `dec_valid`.
- R4: A reserved opcode with `ext_present`=1 and `ext_cover[opcode[2:0]]`=1 raises `ext_start` for exactly one cycle, which is the cycle it first appears. No further start is raised while the operation is in flight.
- R5: `stall` is high from the start cycle for LAT cycles (default 4). `ext_done` rises LAT cycles after the start, and `stall` is low in that same cycle.
- R6: The result is rotl(a, b[4:0]) XOR b, where a and b are `rs1_val` and `rs2_val` as sampled in the start cycle. Later changes to the operand inputs have no effect on it.
- R7: In the cycle after `ext_done`, `wb_en`=1, `wb_rd`=`dec_rd` and `wb_data` is the extension result. An extension opcode never raises `mem_en`.
- R8: A reserved opcode whose `ext_cover` bit is 0 is a no-op even when `ext_present`=1: no start, no stall, no register write and no memory access.
- R9: After reset, `stall`, `ext_start`, `ext_done` and `wb_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_valid | input | 1 | A valid instruction is at decode |
| dec_opcode | input | 6 | Decoded opcode |
| dec_rs1 | input | 5 | First source register number |
| dec_rs2 | input | 5 | Second source register number |
| dec_rd | input | 5 | Destination register number |
| rs1_val | input | 32 | First operand value from the register file |
| rs2_val | input | 32 | Second operand value from the register file |
| alu_result | input | 32 | Base datapath result for writeback |
| base_wb_en | input | 1 | Base decode requests a register write |
| base_mem_en | input | 1 | Base decode requests a memory access |
| ext_present | input | 1 | The extension layer is attached |
| ext_cover | input | 8 | Bit i set means reserved opcode 0x38+i is implemented |
| tap_valid | output | 1 | Observation copy of dec_valid |
| tap_opcode | output | 6 | Observation copy of the opcode |
| tap_rs1 | output | 5 | Observation copy of the first source register number |
| tap_rs2 | output | 5 | Observation copy of the second source register number |
| ext_start | output | 1 | One-cycle start pulse to the extension |
| ext_done | output | 1 | The extension result is ready |
| stall | output | 1 | Hold the pipeline |
| mem_en | output | 1 | Memory access enable after suppression |
| wb_en | output | 1 | Register write enable |
| wb_rd | output | 5 | Register write address |
| wb_data | output | 32 | Register write data |

## Verification
The two functions that meet in one cycle are the release of the stall and the selection of the extension result in the writeback multiplexer. When `ext_done` rises, `stall` must fall in that same cycle, and on the next edge writeback must take the extension result rather than the ALU value. The bench sweeps all 64 opcodes against several coverage masks, both with and without the extension attached. It scrambles the operand inputs during each stall, counts the stall cycles to the exact release, and then compares the written data with a rotate-XOR computed arithmetically from the operands sampled at start.

// File: rtl/ext_hook_unit.sv
module ext_hook_unit #(
  parameter int OPW = 6,
  parameter int RW  = 5,
  parameter int DW  = 32,
  parameter int LAT = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dec_valid,
  input  logic [OPW-1:0] dec_opcode,
  input  logic [RW-1:0]  dec_rs1,
  input  logic [RW-1:0]  dec_rs2,
  input  logic [RW-1:0]  dec_rd,
  input  logic [DW-1:0]  rs1_val,
  input  logic [DW-1:0]  rs2_val,
  input  logic [DW-1:0]  alu_result,
  input  logic           base_wb_en,
  input  logic           base_mem_en,
  input  logic           ext_present,
  input  logic [7:0]     ext_cover,
  output logic           tap_valid,
  output logic [OPW-1:0] tap_opcode,
  output logic [RW-1:0]  tap_rs1,
  output logic [RW-1:0]  tap_rs2,
  output logic           ext_start,
  output logic           ext_done,
  output logic           stall,
  output logic           mem_en,
  output logic           wb_en,
  output logic [RW-1:0]  wb_rd,
  output logic [DW-1:0]  wb_data
);
  localparam int CW = $clog2(LAT + 1);
  localparam int SW = $clog2(DW);

  logic          is_res, covered, busy;
  logic [CW-1:0] cnt;
  logic [DW-1:0] op_a, op_b, ext_result;
  logic [2*DW-1:0] rot_w;

  assign tap_valid  = dec_valid;
  assign tap_opcode = dec_opcode;
  assign tap_rs1    = dec_rs1;
  assign tap_rs2    = dec_rs2;

  assign is_res    = dec_valid && (&dec_opcode[OPW-1:3]);
  assign covered   = ext_present && ext_cover[dec_opcode[2:0]];
  assign ext_start = is_res && covered && !busy;
  assign ext_done  = busy && (cnt == '0);
  assign stall     = ext_start || (busy && !ext_done);
  assign mem_en    = dec_valid && !is_res && base_mem_en;

  assign rot_w      = {op_a, op_a} << op_b[SW-1:0];
  assign ext_result = rot_w[2*DW-1:DW] ^ op_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      op_a <= '0;
      op_b <= '0;
    end else if (ext_start) begin
      busy <= 1'b1;
      cnt  <= CW'(LAT - 1);
      op_a <= rs1_val;
      op_b <= rs2_val;
    end else if (ext_done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_en   <= 1'b0;
      wb_rd   <= '0;
      wb_data <= '0;
    end else begin
      wb_en   <= dec_valid && !stall && (is_res ? ext_done : base_wb_en);
      wb_rd   <= dec_rd;
      wb_data <= ext_done ? ext_result : alu_result;
    end
  end
endmodule

module ext_hook_chk #(
  parameter int OPW = 6,
  parameter int RW  = 5,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           dec_valid,
  input logic [OPW-1:0] dec_opcode,
  input logic [DW-1:0]  alu_result,
  input logic           base_wb_en,
  input logic           ext_present,
  input logic [7:0]     ext_cover,
  input logic           ext_start,
  input logic           ext_done,
  input logic           stall,
  input logic           mem_en,
  input logic           wb_en,
  input logic [DW-1:0]  wb_data
);
  logic res_op;
  assign res_op = dec_valid && (&dec_opcode[OPW-1:3]);

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_start |=> !ext_start);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_start |=> (stall || ext_done));

  // R7
  done_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_done |=> wb_en);

  // R8
  noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_op && !(ext_present && ext_cover[dec_opcode[2:0]])) |-> (!stall && !mem_en && !ext_start));

  // R1
  noop_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_op && !ext_present) |=> !wb_en);

  // R2
  base_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !res_op) |=> (wb_en == $past(base_wb_en) && wb_data == $past(alu_result)));
endmodule

bind ext_hook_unit ext_hook_chk #(.OPW(OPW), .RW(RW), .DW(DW)) u_chk (.*);

// File: tb/tb_ext_hook_unit.sv
`timescale 1ns/1ps
module tb_ext_hook_unit;
  localparam int LAT = 4;
  logic clk = 0, rst_n = 0;
  logic dec_valid = 0;
  logic [5:0] dec_opcode = 0;
  logic [4:0] dec_rs1 = 0, dec_rs2 = 0, dec_rd = 0;
  logic [31:0] rs1_val = 0, rs2_val = 0, alu_result = 0;
  logic base_wb_en = 0, base_mem_en = 0, ext_present = 0;
  logic [7:0] ext_cover = 0;
  logic tap_valid, ext_start, ext_done, stall, mem_en, wb_en;
  logic [5:0] tap_opcode;
  logic [4:0] tap_rs1, tap_rs2, wb_rd;
  logic [31:0] wb_data;
  int tests = 0, fails = 0;

  ext_hook_unit dut (.*);

  always #10 clk = ~clk;

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rotx(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] w;
    w = {a, a} << b[4:0];
    return w[63:32] ^ b;
  endfunction

  task automatic run(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b,
                     input logic [4:0] rd, input logic bw, input logic bm, input logic [31:0] alu);
    logic res, ext;
    int n;
    res = (op[5:3] == 3'b111);
    ext = res && ext_present && ext_cover[op[2:0]];
    @(negedge clk);
    dec_valid = 1; dec_opcode = op; dec_rs1 = a[4:0]; dec_rs2 = b[9:5]; dec_rd = rd;
    rs1_val = a; rs2_val = b; alu_result = alu; base_wb_en = bw; base_mem_en = bm;
    #1;
    chk("R3 tap_opcode", 32'(tap_opcode), 32'(op));
    chk("R3 tap_rs", {tap_rs1, tap_rs2, 21'd0, tap_valid}, {a[4:0], b[9:5], 21'd0, 1'b1});
    chk(res ? "R7/R1 mem_en" : "R2 mem_en", 32'(mem_en), 32'(!res && bm));
    chk(res ? (ext ? "R4 start" : "R8/R1 start") : "R2 start", 32'(ext_start), 32'(ext));
    chk(res ? (ext ? "R5 stall" : "R8/R1 stall") : "R2 stall", 32'(stall), 32'(ext));
    if (ext) begin
      n = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        rs1_val = ~rs1_val ^ 32'h5A5A_1234;
        rs2_val = rs2_val + 32'h0101_0037;
        #1;
        n++;
        if (ext_done) break;
        chk("R4 no restart", 32'(ext_start), 32'd0);
        chk("R5 stall held", 32'(stall), 32'd1);
      end
      chk("R5 latency", 32'(n), 32'(LAT));
      chk("R5 release", 32'(stall), 32'd0);
      chk("R7 mem_en", 32'(mem_en), 32'd0);
    end
    @(negedge clk);
    dec_valid = 0;
    #1;
    if (ext) begin
      chk("R7 wb_en", 32'(wb_en), 32'd1);
      chk("R7 wb_rd", 32'(wb_rd), 32'(rd));
      chk("R6 result", wb_data, rotx(a, b));
    end else if (res) begin
      chk(ext_present ? "R8 wb_en" : "R1 wb_en", 32'(wb_en), 32'd0);
    end else begin
      chk("R2 wb_en", 32'(wb_en), 32'(bw));
      if (bw) begin
        chk("R2 wb_rd", 32'(wb_rd), 32'(rd));
        chk("R2 wb_data", wb_data, alu);
      end
    end
  endtask

  initial begin
    logic [7:0] masks [4];
    masks[0] = 8'hFF; masks[1] = 8'hA5; masks[2] = 8'h5A; masks[3] = 8'h00;
    #25;
    chk("R9 stall", 32'(stall), 32'd0);
    chk("R9 start/done", {30'd0, ext_start, ext_done}, 32'd0);
    chk("R9 wb_en", 32'(wb_en), 32'd0);
    @(negedge clk); rst_n = 1;
    for (int p = 0; p < 2; p++) begin
      for (int m = 0; m < 4; m++) begin
        ext_present = p[0];
        ext_cover = masks[m];
        for (int op = 0; op < 64; op++) begin
          logic [31:0] a, b;
          a = 32'h9E37_79B9 * (op + 1) + 32'(m * 977);
          b = 32'h85EB_CA6B * (op + 3) ^ 32'(p * 31 + m);
          run(6'(op), a, b, 5'(op + m), op[0], op[1], a + b);
        end
      end
    end
    ext_present = 1; ext_cover = 8'hFF;
    run(6'h3F, 32'h8000_0001, 32'h0000_0000, 5'd7, 1'b1, 1'b1, 32'h1);
    run(6'h38, 32'h8000_0001, 32'h0000_001F, 5'd31, 1'b0, 1'b0, 32'h2);
    run(6'h00, 32'h0, 32'h0, 5'd0, 1'b1, 1'b0, 32'hDEAD_BEEF);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule